// File: doc/BRIEF.md
# Filtered External Interrupt Trigger Unit

This block takes a set of asynchronous external interrupt pins, sixteen by default, and turns each one into a pending flag. Every pin goes through its own synchronizer and then a digital glitch filter. A level change reaches the trigger logic only after the synchronized pin has held the new level for more than three clocks. The filtered level is then judged against a trigger mode that is chosen per pin. There are five modes: active-low level, active-high level, falling edge, rising edge, and both edges.

Each pending bit is readable over a small register bus, and software clears it by writing a one to it. A per-pin mask decides which pending bits drive the combined interrupt line. The same unmasked pending bits also drive a wakeup request for a low-power controller. The wakeup request only counts pins that are currently configured for the external-interrupt function, and only while the wakeup-enable input is high. A separate per-pin input reports whether each pin is set to that function. A pin without the function never becomes pending.

Top module: `pinirq_hub`

## Requirements
- R1: After reset, every trigger mode reads 000, every mask bit reads 1, no pending bit is set, and `irq_o` and `wake_o` are low. Idle pins are assumed high.
- R2: The register map has four word addresses.
  - Address 0 holds the modes of pins 0 to 7, and address 1 holds the modes of pins 8 to 15. Pin i uses bits 4(i mod 8)+2 down to 4(i mod 8), and bit 4(i mod 8)+3 reads 0.
  - Address 2 holds the mask, with bit i = 1 masking pin i.
  - Address 3 reads the pending bits. Writing it clears each bit written as 1 and leaves the mask and the modes unchanged.
- R3: A pin level is accepted only after its synchronized value has differed from the filtered level for 4 consecutive clocks. A pulse of 3 clocks or fewer has no effect on the pending bits.
- R4: The edge modes are 010 (falling), 011 (rising) and 1xx (both edges). An accepted edge of the selected kind sets the pin's pending bit, and the bit stays set until a write-one-to-clear. Clearing one bit leaves the other bits unchanged.
- R5: The level modes are 000 (low active) and 001 (high active). While the filtered level is active, the pending bit is set on every clock, so a clear has no lasting effect. Once the level is inactive, the bit stays set until it is cleared.
- R6: When a new trigger and a write-one-to-clear of the same bit meet in the same clock, the bit stays set.
- R7: `irq_o` is high exactly when some pending bit is set and its mask bit is 0. The mask does not affect the pending bits as read back.
- R8: `wake_o` is high exactly when `wake_en_i` is high and some pin that has its function-select bit at 1 is pending and unmasked.
- R9: A pin whose `eint_func_i` bit is 0 never sets its pending bit, whatever its mode or activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eint_pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| eint_func_i | input | NUM_PINS | 1 = pin is configured for the external-interrupt function |
| wake_en_i | input | 1 | Low-power controller accepts wakeup requests |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Combined unmasked interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
A new trigger and a software clear can hit the same pending bit in the same clock. The bench provokes this by releasing a pin in both-edges mode and timing the write-one-to-clear to land in the exact clock where the filtered edge sets the bit. It expects the bit to still read 1. It then repeats the sequence with the clear one clock later and expects 0, which confirms that the collision timing was hit rather than missed.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

   typedef enum logic [2:0] {
      TRIG_LOW  = 3'd0,
      TRIG_HIGH = 3'd1,
      TRIG_FALL = 3'd2,
      TRIG_RISE = 3'd3,
      TRIG_BOTH = 3'd4
   } trig_e;

   localparam int MODE_BITS  = 3;
   localparam int FIELD_BITS = 4;

   function automatic trig_e decode_mode(input logic [MODE_BITS-1:0] raw);
      trig_e t;
      if (raw[2])
         t = TRIG_BOTH;
      else begin
         case (raw[1:0])
            2'd0:    t = TRIG_LOW;
            2'd1:    t = TRIG_HIGH;
            2'd2:    t = TRIG_FALL;
            default: t = TRIG_RISE;
         endcase
      end
      return t;
   endfunction

endpackage

// File: rtl/pinirq_filter.sv
module pinirq_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_LEN    = 4,
   parameter logic IDLE        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o
);

   logic sync_w;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("pinirq_filter: SYNC_STAGES must be at least 1");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("pinirq_filter: FILT_LEN must be at least 1");
   end

   // synchronizer chain
   if (SYNC_STAGES == 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= IDLE;
         else        s_q <= pin_i;
      end
      assign sync_w = s_q;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= {SYNC_STAGES{IDLE}};
         else        s_q <= {s_q[SYNC_STAGES-2:0], pin_i};
      end
      assign sync_w = s_q[SYNC_STAGES-1];
   end

   // glitch filter: accept a level after FILT_LEN differing samples
   if (FILT_LEN == 1) begin : g_nofilt
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= IDLE;
         else        lvl_q <= sync_w;
      end
      assign level_o = lvl_q;
   end else begin : g_filt
      localparam int CNT_W = $clog2(FILT_LEN);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);
      logic [CNT_W-1:0] cnt_q;
      logic             lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= IDLE;
         end else if (sync_w != lvl_q) begin
            if (cnt_q == CNT_LAST) begin
               lvl_q <= sync_w;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
      assign level_o = lvl_q;
   end

   AST_FILT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != $past(level_o)) |-> ($past(sync_w) != $past(level_o))); // R3

endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
   import pinirq_pkg::*;
#(
   parameter int   NUM_PINS = 16,
   parameter logic IDLE     = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PINS-1:0]           level_i,
   input  logic [NUM_PINS*MODE_BITS-1:0] mode_i,
   input  logic [NUM_PINS-1:0]           func_i,
   input  logic [NUM_PINS-1:0]           clr_i,
   output logic [NUM_PINS-1:0]           pend_o
);

   logic [NUM_PINS-1:0] lvl_q;
   logic [NUM_PINS-1:0] hit;
   logic [NUM_PINS-1:0] pend_q;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_comb begin
         case (decode_mode(mode_i[i*MODE_BITS +: MODE_BITS]))
            TRIG_LOW:  hit[i] = ~level_i[i];
            TRIG_HIGH: hit[i] =  level_i[i];
            TRIG_FALL: hit[i] =  lvl_q[i] & ~level_i[i];
            TRIG_RISE: hit[i] = ~lvl_q[i] &  level_i[i];
            default:   hit[i] =  lvl_q[i] ^  level_i[i];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= {NUM_PINS{IDLE}};
         pend_q <= '0;
      end else begin
         lvl_q  <= level_i;
         pend_q <= (pend_q & ~clr_i) | (hit & func_i);
      end
   end

   assign pend_o = pend_q;

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0)); // R4
   AST_NO_FOREIGN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(func_i)) == '0)); // R9

endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
   import pinirq_pkg::*;
#(
   parameter int NUM_PINS   = 16,
   parameter int DATA_W     = 32,
   parameter int PPW        = 8,
   parameter int MODE_WORDS = 2,
   parameter int ADDR_W     = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_en_i,
   input  logic                          bus_we_i,
   input  logic [ADDR_W-1:0]             bus_addr_i,
   input  logic [DATA_W-1:0]             bus_wdata_i,
   output logic [DATA_W-1:0]             bus_rdata_o,
   input  logic [NUM_PINS-1:0]           pend_i,
   output logic [NUM_PINS*MODE_BITS-1:0] mode_o,
   output logic [NUM_PINS-1:0]           mask_o,
   output logic [NUM_PINS-1:0]           clr_o
);

   localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MODE_WORDS);
   localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(MODE_WORDS + 1);

   logic                          wr;
   logic [NUM_PINS*MODE_BITS-1:0] mode_q;
   logic [NUM_PINS-1:0]           mask_q;
   logic                          unused_wdata;

   assign wr           = bus_en_i & bus_we_i;
   assign unused_wdata = ^bus_wdata_i;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_mode
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(i / PPW);
      localparam int                LSB   = FIELD_BITS * (i % PPW);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mode_q[i*MODE_BITS +: MODE_BITS] <= '0;
         else if (wr && bus_addr_i == WADDR)
            mode_q[i*MODE_BITS +: MODE_BITS] <= bus_wdata_i[LSB +: MODE_BITS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '1;
      else if (wr && bus_addr_i == MASK_ADDR)
         mask_q <= bus_wdata_i[NUM_PINS-1:0];
   end

   assign clr_o  = (wr && bus_addr_i == PEND_ADDR) ? bus_wdata_i[NUM_PINS-1:0] : '0;
   assign mode_o = mode_q;
   assign mask_o = mask_q;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == MASK_ADDR)
         bus_rdata_o[NUM_PINS-1:0] = mask_q;
      else if (bus_addr_i == PEND_ADDR)
         bus_rdata_o[NUM_PINS-1:0] = pend_i;
      else begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_addr_i == ADDR_W'(i / PPW))
               bus_rdata_o[FIELD_BITS*(i % PPW) +: MODE_BITS] =
                  mode_q[i*MODE_BITS +: MODE_BITS];
         end
      end
   end

   AST_CLR_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr && bus_addr_i == PEND_ADDR) |-> $stable(mask_q)); // R2

endmodule

// File: rtl/pinirq_hub.sv
module pinirq_hub
   import pinirq_pkg::*;
#(
   parameter int   NUM_PINS    = 16,
   parameter int   DATA_W      = 32,
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_LEN    = 4,
   parameter logic IDLE        = 1'b1,
   localparam int  PPW         = DATA_W / FIELD_BITS,
   localparam int  MODE_WORDS  = (NUM_PINS + PPW - 1) / PPW,
   localparam int  ADDR_W      = $clog2(MODE_WORDS + 2)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] eint_pin_i,
   input  logic [NUM_PINS-1:0] eint_func_i,
   input  logic                wake_en_i,
   input  logic                bus_en_i,
   input  logic                bus_we_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic                irq_o,
   output logic                wake_o
);

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("pinirq_hub: NUM_PINS must lie in 1..DATA_W");
   end
   if (DATA_W % FIELD_BITS != 0) begin : g_bad_width
      $error("pinirq_hub: DATA_W must be a multiple of the mode field width");
   end

   logic [NUM_PINS-1:0]           level_w;
   logic [NUM_PINS*MODE_BITS-1:0] mode_w;
   logic [NUM_PINS-1:0]           mask_w;
   logic [NUM_PINS-1:0]           clr_w;
   logic [NUM_PINS-1:0]           pend_w;
   logic [NUM_PINS-1:0]           live_w;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_in
      pinirq_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN),
         .IDLE       (IDLE)
      ) u_filter (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (eint_pin_i[i]),
         .level_o(level_w[i])
      );
   end

   pinirq_detect #(
      .NUM_PINS(NUM_PINS),
      .IDLE    (IDLE)
   ) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_i(level_w),
      .mode_i (mode_w),
      .func_i (eint_func_i),
      .clr_i  (clr_w),
      .pend_o (pend_w)
   );

   pinirq_regs #(
      .NUM_PINS  (NUM_PINS),
      .DATA_W    (DATA_W),
      .PPW       (PPW),
      .MODE_WORDS(MODE_WORDS),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en_i   (bus_en_i),
      .bus_we_i   (bus_we_i),
      .bus_addr_i (bus_addr_i),
      .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o),
      .pend_i     (pend_w),
      .mode_o     (mode_w),
      .mask_o     (mask_w),
      .clr_o      (clr_w)
   );

   assign live_w = pend_w & ~mask_w;
   assign irq_o  = |live_w;
   assign wake_o = wake_en_i & |(live_w & eint_func_i);

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend_w != '0)); // R7
   AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_en_i || eint_func_i == '0) |-> !wake_o); // R8

endmodule

// File: tb/pinirq_hub_bench.sv
`timescale 1ns/1ps
module pinirq_hub_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pins = 16'hFFFF;
   logic [15:0] func = 16'hFFFF;
   logic        wake_en = 1'b1;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, wake;

   int total = 0;
   int bad   = 0;
   logic [31:0] rv;

   always #4 clk = ~clk;

   pinirq_hub u_pinirq_hub (
      .clk(clk), .rst_n(rst_n), .eint_pin_i(pins), .eint_func_i(func),
      .wake_en_i(wake_en), .bus_en_i(bus_en), .bus_we_i(bus_we),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .irq_o(irq), .wake_o(wake)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expected pending of one pin in the sweep, per phase
   function automatic logic sweep_exp(input int m, input int ph);
      case (ph)
         0: return m == 1;
         1: return m != 3;
         2: return m == 0;
         3: return m != 2;
         default: return m == 1;
      endcase
   endfunction

   task automatic sweep_check(input int rot, input int ph);
      logic [31:0] e;
      logic [31:0] got;
      e = '0;
      for (int i = 0; i < 16; i++) e[i] = sweep_exp((rot + i) % 8, ph);
      rd(2'd3, got);
      chk($sformatf("R4/R5 sweep rot=%0d phase=%0d", rot, ph), got, e);
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      settle(3);
      rst_n = 1'b1;
      settle(2);

      // R1 reset state
      rd(2'd0, rv); chk("R1 mode word0", rv, 32'h0);
      rd(2'd1, rv); chk("R1 mode word1", rv, 32'h0);
      rd(2'd2, rv); chk("R1 mask", rv, 32'h0000FFFF);
      rd(2'd3, rv); chk("R1 pending", rv, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 wake", {31'b0, wake}, 32'h0);

      // R2 field layout
      wr(2'd0, 32'hFFFFFFFF);
      rd(2'd0, rv); chk("R2 mode word0 spare bits", rv, 32'h77777777);
      wr(2'd1, 32'h12345670);
      rd(2'd1, rv); chk("R2 mode word1", rv, 32'h12345670);
      wr(2'd3, 32'hFFFF);
      rd(2'd2, rv); chk("R2 clear keeps mask", rv, 32'h0000FFFF);

      // R4/R5 sweep: every pin through every mode value
      for (int rot = 0; rot < 8; rot++) begin
         logic [31:0] w0, w1;
         w0 = '0; w1 = '0;
         for (int i = 0; i < 8; i++) begin
            w0[4*i +: 3] = 3'((rot + i) % 8);
            w1[4*i +: 3] = 3'((rot + i + 8) % 8);
         end
         wr(2'd0, w0);
         wr(2'd1, w1);
         settle(2);
         wr(2'd3, 32'hFFFF); settle(3); sweep_check(rot, 0);
         pins = 16'h0000;    settle(12); sweep_check(rot, 1);
         wr(2'd3, 32'hFFFF); settle(3); sweep_check(rot, 2);
         pins = 16'hFFFF;    settle(12); sweep_check(rot, 3);
         wr(2'd3, 32'hFFFF); settle(3); sweep_check(rot, 4);
      end

      // R3 filter boundary: 3-clock pulse ignored, 4-clock pulse taken
      wr(2'd0, 32'h22222222);
      wr(2'd1, 32'h22222222);
      settle(2);
      wr(2'd3, 32'hFFFF);
      @(negedge clk); pins[0] = 1'b0; pins[1] = 1'b0; pins[2] = 1'b0;
      @(negedge clk); pins[2] = 1'b1;
      settle(2);      pins[0] = 1'b1;
      @(negedge clk); pins[1] = 1'b1;
      settle(12);
      rd(2'd3, rv); chk("R3 pulses 2/3 ignored, 4 accepted", rv, 32'h0002);

      // R4 single-bit clear leaves others
      @(negedge clk); pins[5] = 1'b0; settle(8); pins[5] = 1'b1; settle(10);
      wr(2'd3, 32'h0002);
      rd(2'd3, rv); chk("R4 clear one bit", rv, 32'h0020);
      wr(2'd3, 32'hFFFF);

      // R6 collision: clear lands in the set clock
      wr(2'd0, 32'h44444444);
      settle(2);
      @(negedge clk); pins[0] = 1'b0; settle(10);
      rd(2'd3, rv); chk("R4 both-edges falling sets", rv, 32'h0001);
      @(negedge clk); pins[0] = 1'b1;
      settle(6);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h1;
      @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
      rd(2'd3, rv); chk("R6 set wins over same-cycle clear", rv, 32'h0001);
      wr(2'd3, 32'h1);
      rd(2'd3, rv); chk("R4 sticky bit cleared", rv, 32'h0);
      // control: clear one clock after the set clears it
      @(negedge clk); pins[0] = 1'b0;
      settle(7);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h1;
      @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
      rd(2'd3, rv); chk("R6 clear one clock later wins", rv, 32'h0);
      @(negedge clk); pins[0] = 1'b1; settle(12);
      wr(2'd3, 32'hFFFF);

      // R7 mask and irq
      wr(2'd0, 32'h22222222);
      settle(2);
      @(negedge clk); pins[3] = 1'b0; settle(8); pins[3] = 1'b1; settle(10);
      rd(2'd3, rv); chk("R7 pending visible while masked", rv, 32'h0008);
      chk("R7 masked irq low", {31'b0, irq}, 32'h0);
      wr(2'd2, 32'h0000FFDF);
      settle(1); chk("R7 unmasked idle pin no irq", {31'b0, irq}, 32'h0);
      wr(2'd2, 32'h0000FFF7);
      settle(1); chk("R7 unmasked pending irq", {31'b0, irq}, 32'h1);

      // R8 wakeup
      wake_en = 1'b0; settle(1); chk("R8 wake off when disabled", {31'b0, wake}, 32'h0);
      wake_en = 1'b1; settle(1); chk("R8 wake on", {31'b0, wake}, 32'h1);
      func[3] = 1'b0; settle(1); chk("R8 wake needs function", {31'b0, wake}, 32'h0);
      chk("R8 irq unaffected by function", {31'b0, irq}, 32'h1);
      func[3] = 1'b1;
      wr(2'd3, 32'hFFFF);

      // R9 pin without function never pends
      func[7] = 1'b0;
      @(negedge clk); pins[7] = 1'b0; pins[6] = 1'b0; settle(8);
      pins[7] = 1'b1; pins[6] = 1'b1; settle(10);
      rd(2'd3, rv); chk("R9 non-function pin ignored", rv, 32'h0040);
      wr(2'd0, 32'h00000000);
      @(negedge clk); pins[7] = 1'b0; settle(10);
      rd(2'd3, rv); chk("R9 level mode ignored too", rv & 32'h80, 32'h0);
      pins[7] = 1'b1;
      func[7] = 1'b1;
      settle(4);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule